// File: doc/BRIEF.md
# Millisecond Ramp DAC Stepper

This block moves a 16-bit DAC code toward a target level in fixed steps, one step for each millisecond tick. A segment is described by a signed step of 32 bits (16 integer bits over 16 fractional bits), a count of updates and a start level. The step is summed into a 32-bit accumulator whose upper half is the DAC code, so slow slopes that move less than one code per millisecond still progress smoothly. The update count ends the segment: each applied tick takes one off, and when it reaches zero the code freezes and a done pulse is issued.

Software or a sequencer computes the step and the count from the wanted slope and level difference, then issues a load. A load while idle positions the output at the start level at once. A load while a ramp is running is parked and takes over at the next enabled tick, starting from the present output, so a segment chain has no discontinuity. The enable gates the tick: with it low the block freezes in place.

Top module: `ramp_stepper`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, dac_code_o is 0x0000, busy_o is 0 and done_o is 0.
- R2: A load_i pulse while busy_o is 0 sets dac_code_o to load_level_i and clears the fraction in the cycle after the load; busy_o then equals (load_count_i != 0).
- R3: Each applied tick adds load_step_i, a two's complement value with bits 31:16 the integer part and bits 15:0 the fraction, to the 32-bit accumulator; dac_code_o is accumulator bits 31:16 and changes in the cycle after the tick.
- R4: Exactly load_count_i ticks are applied per segment; afterwards busy_o is 0 and further ticks leave dac_code_o unchanged.
- R5: done_o is high for exactly one cycle, the cycle after the tick that takes the count from 1 to 0, and busy_o is 0 in that cycle.
- R6: A tick_i pulse with enable_i low has no effect: dac_code_o holds and busy_o stays as it was.
- R7: The accumulator saturates: a rising step that would pass the top gives dac_code_o 0xFFFF, a falling step that would go below zero gives 0x0000.
- R8: A load_i pulse while busy_o is 1 leaves dac_code_o unchanged and ignores load_level_i; at the next enabled tick the new step is applied from the current accumulator and the new count, minus that tick, replaces the old one.
- R9: A load with load_count_i of zero while idle sets the level but keeps busy_o at 0, and no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load strobe for a new segment, one cycle |
| load_step_i | input | 32 | Signed step per tick, 16.16 fixed point |
| load_count_i | input | 16 | Number of ticks in the segment |
| load_level_i | input | 16 | Start code, used only when idle |
| enable_i | input | 1 | Tick gate |
| tick_i | input | 1 | Millisecond update strobe, one cycle |
| dac_code_o | output | 16 | DAC code |
| busy_o | output | 1 | Segment in progress |
| done_o | output | 1 | One-cycle pulse at segment end |

## Verification
The bench aims at fractional steps that only show up after several ticks, at both saturation ends, at a count of zero and at ticks arriving after the count has run out; a design that dropped the fraction, wrapped instead of clamping or stepped once too often would show a wrong code. It reloads during a falling continuation of a rising ramp, where an implementation that applied the parked start level would jump, and one that adopted the new segment a tick late would land one code off. It gates ticks with the enable low and watches the done pulse width, so a block that counted gated ticks or held done for two cycles is caught.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
  localparam int unsigned RAMP_CODE_W = 16;
  localparam int unsigned RAMP_FRAC_W = 16;
  localparam int unsigned RAMP_CNT_W  = 16;
endpackage

// File: rtl/ramp_seg_sel.sv
// Active step and parked segment; decides when a parked segment takes over.
module ramp_seg_sel #(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_idle_i,
  input  logic             load_busy_i,
  input  logic [ACC_W-1:0] load_step_i,
  input  logic [CNT_W-1:0] load_cnt_i,
  input  logic             tick_en_i,
  output logic             take_pend_o,
  output logic [CNT_W-1:0] pend_cnt_o,
  output logic [ACC_W-1:0] eff_step_o
);
  logic [ACC_W-1:0] step_q, pend_step_q;
  logic [CNT_W-1:0] pend_cnt_q;
  logic             pend_v_q;

  assign take_pend_o = tick_en_i & pend_v_q;
  assign pend_cnt_o  = pend_cnt_q;
  assign eff_step_o  = take_pend_o ? pend_step_q : step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q      <= '0;
      pend_step_q <= '0;
      pend_cnt_q  <= '0;
      pend_v_q    <= 1'b0;
    end else if (load_idle_i) begin
      step_q   <= load_step_i;
      pend_v_q <= 1'b0;
    end else begin
      if (take_pend_o) step_q <= pend_step_q;
      if (load_busy_i) begin
        pend_step_q <= load_step_i;
        pend_cnt_q  <= load_cnt_i;
        pend_v_q    <= 1'b1;
      end else if (take_pend_o) begin
        pend_v_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ramp_counter.sv
// Update-count terminator and done pulse.
module ramp_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_idle_i,
  input  logic [CNT_W-1:0] load_cnt_i,
  input  logic             take_pend_i,
  input  logic [CNT_W-1:0] pend_cnt_i,
  input  logic             tick_en_i,
  output logic             step_en_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, eff_cnt;
  logic             done_q;

  assign eff_cnt   = take_pend_i ? pend_cnt_i : cnt_q;
  assign step_en_o = tick_en_i & (eff_cnt != '0);
  assign busy_o    = (cnt_q != '0);
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (load_idle_i) begin
      cnt_q  <= load_cnt_i;
      done_q <= 1'b0;
    end else begin
      done_q <= step_en_o & (eff_cnt == ONE);
      if (step_en_o)        cnt_q <= eff_cnt - ONE;
      else if (take_pend_i) cnt_q <= '0;
    end
  end
endmodule

// File: rtl/ramp_accum.sv
// Fixed-point accumulator with clamping at both ends of the code range.
module ramp_accum #(
  parameter int unsigned CODE_W = 16,
  parameter int unsigned FRAC_W = 16,
  localparam int unsigned ACC_W = CODE_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_idle_i,
  input  logic [CODE_W-1:0] load_level_i,
  input  logic              step_en_i,
  input  logic [ACC_W-1:0]  step_i,
  output logic [CODE_W-1:0] code_o
);
  logic [ACC_W-1:0]        acc_q, acc_sat;
  logic signed [ACC_W+1:0] sum;

  always_comb begin
    sum = $signed({2'b00, acc_q}) + $signed({{2{step_i[ACC_W-1]}}, step_i});
    if (sum[ACC_W+1])    acc_sat = '0;      // fell below zero
    else if (sum[ACC_W]) acc_sat = '1;      // passed the top
    else                 acc_sat = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          acc_q <= '0;
    else if (load_idle_i) acc_q <= {load_level_i, {FRAC_W{1'b0}}};
    else if (step_en_i)   acc_q <= acc_sat;
  end

  assign code_o = acc_q[ACC_W-1:FRAC_W];
endmodule

// File: rtl/ramp_stepper.sv
module ramp_stepper
  import ramp_pkg::*;
#(
  parameter int unsigned CODE_W = RAMP_CODE_W,
  parameter int unsigned FRAC_W = RAMP_FRAC_W,
  parameter int unsigned CNT_W  = RAMP_CNT_W,
  localparam int unsigned ACC_W = CODE_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ACC_W-1:0]  load_step_i,
  input  logic [CNT_W-1:0]  load_count_i,
  input  logic [CODE_W-1:0] load_level_i,
  input  logic              enable_i,
  input  logic              tick_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              busy_o,
  output logic              done_o
);
  logic             load_idle, load_busy, tick_en;
  logic             take_pend, step_en, busy;
  logic [CNT_W-1:0] pend_cnt;
  logic [ACC_W-1:0] eff_step;

  assign tick_en   = tick_i & enable_i;
  assign load_idle = load_i & ~busy;
  assign load_busy = load_i & busy;

  ramp_seg_sel #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_seg (
    .clk_i, .rst_ni,
    .load_idle_i (load_idle),
    .load_busy_i (load_busy),
    .load_step_i (load_step_i),
    .load_cnt_i  (load_count_i),
    .tick_en_i   (tick_en),
    .take_pend_o (take_pend),
    .pend_cnt_o  (pend_cnt),
    .eff_step_o  (eff_step)
  );

  ramp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .load_idle_i (load_idle),
    .load_cnt_i  (load_count_i),
    .take_pend_i (take_pend),
    .pend_cnt_i  (pend_cnt),
    .tick_en_i   (tick_en),
    .step_en_o   (step_en),
    .busy_o      (busy),
    .done_o      (done_o)
  );

  ramp_accum #(.CODE_W(CODE_W), .FRAC_W(FRAC_W)) u_acc (
    .clk_i, .rst_ni,
    .load_idle_i  (load_idle),
    .load_level_i (load_level_i),
    .step_en_i    (step_en),
    .step_i       (eff_step),
    .code_o       (dac_code_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/ramp_stepper_chk.sv
module ramp_stepper_chk #(
  parameter int unsigned CODE_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [CODE_W-1:0] load_level_i,
  input logic              enable_i,
  input logic              tick_i,
  input logic [CODE_W-1:0] dac_code_o,
  input logic              busy_o,
  input logic              done_o
);
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R5
  AST_GATED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !(tick_i && enable_i)) |=> $stable(dac_code_o)); // R6
  AST_IDLE_LOAD_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !busy_o) |=> (dac_code_o == $past(load_level_i))); // R2
  AST_BUSY_LOAD_NO_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && busy_o && !(tick_i && enable_i)) |=> $stable(dac_code_o)); // R8
endmodule

bind ramp_stepper ramp_stepper_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i, .rst_ni, .load_i, .load_level_i, .enable_i, .tick_i,
  .dac_code_o, .busy_o, .done_o
);

// File: tb/ramp_stepper_bench.sv
module ramp_stepper_bench;
  localparam time CLK_P = 10ns;

  typedef struct packed {
    logic [15:0] level;
    logic [31:0] step;
    logic [15:0] count;
    logic [7:0]  ticks;
    logic [15:0] exp_dac;
    logic        exp_busy;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{16'h1000, 32'h0001_8000, 16'd4, 8'd4, 16'h1006, 1'b0},  // R3 rise 1.5
    '{16'h8000, 32'hFFFF_0000, 16'd5, 8'd5, 16'h7FFB, 1'b0},  // R3 fall
    '{16'h0010, 32'h0000_4000, 16'd7, 8'd7, 16'h0011, 1'b0},  // R3 fraction
    '{16'hFFFE, 32'h0002_0000, 16'd3, 8'd3, 16'hFFFF, 1'b0},  // R7 top
    '{16'h0002, 32'hFFFD_0000, 16'd2, 8'd2, 16'h0000, 1'b0},  // R7 bottom
    '{16'h0100, 32'h0010_0000, 16'd2, 8'd5, 16'h0120, 1'b0},  // R4 extra ticks
    '{16'h0300, 32'h0001_0000, 16'd0, 8'd3, 16'h0300, 1'b0},  // R9 zero count
    '{16'h1000, 32'h0001_8000, 16'd4, 8'd3, 16'h1004, 1'b1}   // R4 partial
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        load_i = 1'b0, enable_i = 1'b1, tick_i = 1'b0;
  logic [31:0] load_step_i = '0;
  logic [15:0] load_count_i = '0, load_level_i = '0;
  logic [15:0] dac_code_o;
  logic        busy_o, done_o;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  ramp_stepper u_ramp_stepper (
    .clk_i, .rst_ni, .load_i, .load_step_i, .load_count_i, .load_level_i,
    .enable_i, .tick_i, .dac_code_o, .busy_o, .done_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [15:0] lvl, input logic [31:0] stp, input logic [15:0] cnt);
    @(negedge clk_i);
    load_i = 1'b1; load_level_i = lvl; load_step_i = stp; load_count_i = cnt;
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  task automatic do_tick(input logic en);
    @(negedge clk_i);
    tick_i = 1'b1; enable_i = en;
    @(negedge clk_i);
    tick_i = 1'b0; enable_i = 1'b1;
  endtask

  task automatic drain();
    for (int k = 0; k < 200 && busy_o; k++) do_tick(1'b1);
  endtask

  function automatic string vreq(input int i);
    case (i)
      0, 1, 2: return "R3";
      3, 4:    return "R7";
      6:       return "R9";
      default: return "R4";
    endcase
  endfunction

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 3);
    check("R1 dac in reset", 32'(dac_code_o), 32'h0);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 dac", 32'(dac_code_o), 32'h0);
    check("R1 busy", 32'(busy_o), 32'h0);
    check("R1 done", 32'(done_o), 32'h0);

    for (int i = 0; i < NV; i++) begin
      drain();
      do_load(VECS[i].level, VECS[i].step, VECS[i].count);
      check("R2 start level", 32'(dac_code_o), 32'(VECS[i].level));
      check("R2 busy after load", 32'(busy_o), 32'(VECS[i].count != 0));
      for (int t = 0; t < int'(VECS[i].ticks); t++) do_tick(1'b1);
      check(vreq(i), 32'(dac_code_o), 32'(VECS[i].exp_dac));
      check(vreq(i), 32'(busy_o), 32'(VECS[i].exp_busy));
    end
    drain();

    // R5 done pulse
    do_load(16'h0000, 32'h0001_0000, 16'd2);
    do_tick(1'b1);
    check("R5 no early done", 32'(done_o), 32'h0);
    do_tick(1'b1);
    check("R5 done at end", 32'(done_o), 32'h1);
    check("R5 busy low at done", 32'(busy_o), 32'h0);
    @(negedge clk_i);
    check("R5 done one cycle", 32'(done_o), 32'h0);

    // R9 no done on zero count
    do_load(16'h0040, 32'h0001_0000, 16'd0);
    do_tick(1'b1);
    check("R9 no done", 32'(done_o), 32'h0);

    // R6 gated ticks
    do_load(16'h0050, 32'h0001_0000, 16'd3);
    for (int t = 0; t < 3; t++) do_tick(1'b0);
    check("R6 held code", 32'(dac_code_o), 32'h50);
    check("R6 still busy", 32'(busy_o), 32'h1);
    do_tick(1'b1);
    check("R6 resumes", 32'(dac_code_o), 32'h51);
    drain();

    // R8 reload while running
    do_load(16'h0200, 32'h0001_0000, 16'd10);
    do_tick(1'b1);
    do_tick(1'b1);
    check("R3 two ticks", 32'(dac_code_o), 32'h202);
    do_load(16'h9999, 32'hFFFF_0000, 16'd3);
    check("R8 no jump on load", 32'(dac_code_o), 32'h202);
    do_tick(1'b1);
    check("R8 new step from current", 32'(dac_code_o), 32'h201);
    check("R8 busy", 32'(busy_o), 32'h1);
    do_tick(1'b1);
    do_tick(1'b1);
    check("R8 new count", 32'(dac_code_o), 32'h1FF);
    check("R8 ended", 32'(busy_o), 32'h0);
    check("R5 done after reload", 32'(done_o), 32'h1);
    do_tick(1'b1);
    check("R4 frozen after end", 32'(dac_code_o), 32'h1FF);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule